// File: doc/BRIEF.md
# 3x3 Window Line Buffer

This block turns a raster-ordered pixel stream, one pixel per clock, into a sliding 3x3 neighbourhood for a downstream image kernel such as an edge detector. Every accepted pixel moves the window one column to the right. The kernel receives all nine pixels at once and never has to fetch image data again.

The two previous image lines are held in a single-port RAM. Each RAM word packs two adjacent columns of both stored lines, which is four pixels per word. The port reads a word on an even-column pixel and writes the updated word back on the following odd-column pixel. The line store therefore keeps up with one pixel per clock without a second port.

Because of the read-then-write rhythm, the column for pixel k is shifted into the window when pixel k+1 is accepted. When the input valid flag is low, every register and the RAM hold their state.

Top module: `lb3_window_gen`

## Requirements
- R1: While reset is asserted, and after it until the first window is produced, `win_valid` is low. Reset clears all nine window positions to zero.
- R2: Window position p = 3*ro + co sits at bits [p*PIX_W +: PIX_W] of `win_pix`. Here ro is the row offset and co the column offset, each 0 to 2. For a window belonging to pixel (r,c), position p holds pixel (r-2+ro, c-2+co) of the same frame, so position 8 is (r,c) and position 0 is (r-2,c-2).
- R3: The window for accepted pixel k is shown, with `win_valid` high for exactly one cycle, in the cycle after the clock edge at which the next pixel k+1 is accepted. At no other time is `win_valid` high.
- R4: Columns count 0 to IMG_W-1 and rows count 0 to IMG_H-1, both wrapping. A window is flagged valid only for pixels with r >= 2 and c >= 2, giving (IMG_H-2)*(IMG_W-2) windows per frame.
- R5: `ctr_pix` equals window position 4, which is pixel (r-1,c-1), the centre of the neighbourhood.
- R6: In a cycle with `in_valid` low, nothing advances. In the following cycle `win_valid` is low and `win_pix` is unchanged. Gaps of any length at any column give the same windows as a gap-free stream.
- R7: Every window comes from a single frame. After a frame wraps, the first two rows of the new frame produce no window, and later windows use only new-frame lines.
- R8: The line store is one single-port RAM of IMG_W/2 words, each 4*PIX_W wide. Reads happen on even-column pixels and writes on odd-column pixels, strictly alternating. Windows are correct for both the even and the odd column of each word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel accepted this cycle |
| in_pix | input | PIX_W | Input pixel, raster order |
| win_pix | output | 9*PIX_W | Nine window pixels, position p at bits p*PIX_W |
| win_valid | output | 1 | Window holds a full in-frame neighbourhood |
| ctr_pix | output | PIX_W | Centre pixel of the window (position 4) |

## Verification
The bench drives four frames, each with its own stimulus:
- A coordinate ramp, where every pixel value encodes its own row and column, so any mis-placed window position or off-by-one line delay shows up at once.
- Pseudo-random values with random gaps, which test the stall logic against a gap-free reference.
- A checkerboard stalled between each even and odd column, which holds a RAM word between its read and its write-back.
- A falling ramp stalled at every line end, which exercises the column wrap under stalls.

All windows are compared against a frame-buffer model. Each cycle is also checked to confirm that `win_valid` rises exactly when a window is due and that the window is frozen after an idle cycle.

// File: rtl/lb3_pkg.sv
package lb3_pkg;
   // Window geometry
   localparam int WIN_SIDE   = 3;
   localparam int WIN_TAPS   = WIN_SIDE * WIN_SIDE;
   localparam int CENTRE_POS = 4;
   localparam int NEWEST_POS = WIN_TAPS - 1;

   // Pixels per line-store word: two columns times two stored lines
   localparam int WORD_LANES = 4;

   // Lane order inside a line-store word (lane index times pixel width = offset)
   typedef enum logic [1:0] {
      LANE_L1_LO = 2'd0,   // previous line, even column
      LANE_L2_LO = 2'd1,   // line before that, even column
      LANE_L1_HI = 2'd2,   // previous line, odd column
      LANE_L2_HI = 2'd3    // line before that, odd column
   } lane_e;
endpackage

// File: rtl/lb3_pos_ctr.sv
module lb3_pos_ctr #(
   parameter int IMG_W = 1920,
   parameter int IMG_H = 1080,
   parameter int CW    = $clog2(IMG_W),
   parameter int RW    = $clog2(IMG_H)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [CW-1:0] col,
   output logic [RW-1:0] row
);
   localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
   localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);

   logic end_col;
   logic end_row;

   assign end_col = (col == COL_LAST);
   assign end_row = (row == ROW_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col <= '0;
         row <= '0;
      end else if (adv) begin
         col <= end_col ? '0 : col + CW'(1);
         if (end_col) begin
            row <= end_row ? '0 : row + RW'(1);
         end
      end
   end

   // R4: column wraps at the image width
   p_col_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && col == COL_LAST) |=> (col == '0));

   // R4: row wraps at the image height after the last column
   p_row_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && col == COL_LAST && row == ROW_LAST) |=> (row == '0));

   // R6: no advance without an accepted pixel
   p_hold_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> ($stable(col) && $stable(row)));
endmodule

// File: rtl/lb3_line_ram.sv
module lb3_line_ram #(
   parameter int DEPTH = 960,
   parameter int DW    = 48,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];
   logic          last_was_rd;

   // Single port: one access per enabled cycle; read data registered and held
   always_ff @(posedge clk) begin
      if (en) begin
         if (we) begin
            mem[addr] <= wdata;
         end else begin
            rdata <= mem[addr];
         end
      end
   end

   // Operation history for the alternation check
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_was_rd <= 1'b0;
      end else if (en) begin
         last_was_rd <= !we;
      end
   end

   // R8: every write is preceded by a read
   p_write_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && we) |-> last_was_rd);

   // R8: no two reads without a write between them
   p_read_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !we) |-> !last_was_rd);

   // R8: address stays inside the array
   p_addr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (int'(addr) < DEPTH));
endmodule

// File: rtl/lb3_window.sv
module lb3_window
   import lb3_pkg::*;
#(
   parameter int PIX_W = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      shift,
   input  logic [PIX_W-1:0]          top_px,
   input  logic [PIX_W-1:0]          mid_px,
   input  logic [PIX_W-1:0]          bot_px,
   output logic [WIN_TAPS*PIX_W-1:0] win
);
   logic [PIX_W-1:0] new_col [WIN_SIDE];

   assign new_col[0] = top_px;
   assign new_col[1] = mid_px;
   assign new_col[2] = bot_px;

   for (genvar r = 0; r < WIN_SIDE; r++) begin : g_row
      logic [PIX_W-1:0] tap [WIN_SIDE];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int k = 0; k < WIN_SIDE; k++) tap[k] <= '0;
         end else if (shift) begin
            for (int k = 0; k < WIN_SIDE - 1; k++) tap[k] <= tap[k+1];
            tap[WIN_SIDE-1] <= new_col[r];
         end
      end

      for (genvar k = 0; k < WIN_SIDE; k++) begin : g_tap
         assign win[(r*WIN_SIDE + k)*PIX_W +: PIX_W] = tap[k];
      end
   end

   // R6: window frozen when not shifting
   p_hold_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !shift |=> $stable(win));

   // R2: newest pixel lands at position 8
   p_newest_r2: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> (win[NEWEST_POS*PIX_W +: PIX_W] == $past(bot_px)));

   // R2: pixels move one column left per shift
   p_slide_r2: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> (win[CENTRE_POS*PIX_W +: PIX_W] == $past(win[(CENTRE_POS+1)*PIX_W +: PIX_W])));
endmodule

// File: rtl/lb3_window_gen.sv
module lb3_window_gen
   import lb3_pkg::*;
#(
   parameter int PIX_W = 12,
   parameter int IMG_W = 1920,
   parameter int IMG_H = 1080
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [PIX_W-1:0]          in_pix,
   output logic [WIN_TAPS*PIX_W-1:0] win_pix,
   output logic                      win_valid,
   output logic [PIX_W-1:0]          ctr_pix
);
   localparam int CW    = $clog2(IMG_W);
   localparam int RW    = $clog2(IMG_H);
   localparam int DEPTH = IMG_W / 2;
   localparam int AW    = CW - 1;
   localparam int DW    = WORD_LANES * PIX_W;

   // Elaboration-time parameter checks
   if (IMG_W < 4 || (IMG_W % 2) != 0) begin : g_bad_width
      $error("lb3_window_gen: IMG_W must be even and at least 4");
   end
   if (IMG_H < 3) begin : g_bad_height
      $error("lb3_window_gen: IMG_H must be at least 3");
   end
   if (PIX_W < 1) begin : g_bad_pix
      $error("lb3_window_gen: PIX_W must be positive");
   end

   logic          acc;
   logic [CW-1:0] col;
   logic [RW-1:0] row;

   assign acc = in_valid;

   lb3_pos_ctr #(
      .IMG_W (IMG_W),
      .IMG_H (IMG_H),
      .CW    (CW),
      .RW    (RW)
   ) u_pos (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (acc),
      .col   (col),
      .row   (row)
   );

   // Previous accepted pixel and its coordinates (one-pixel alignment stage)
   logic [PIX_W-1:0] dpix;
   logic [CW-1:0]    dcol;
   logic [RW-1:0]    drow;
   logic             dprimed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dpix    <= '0;
         dcol    <= '0;
         drow    <= '0;
         dprimed <= 1'b0;
      end else if (acc) begin
         dpix    <= in_pix;
         dcol    <= col;
         drow    <= row;
         dprimed <= 1'b1;
      end
   end

   // Line store: read on even columns, write back on odd columns
   logic          ram_we;
   logic [AW-1:0] ram_addr;
   logic [DW-1:0] ram_wdata;
   logic [DW-1:0] ram_rdata;

   logic [PIX_W-1:0] rd_l1_lo, rd_l2_lo, rd_l1_hi, rd_l2_hi;

   assign rd_l1_lo = ram_rdata[int'(LANE_L1_LO)*PIX_W +: PIX_W];
   assign rd_l2_lo = ram_rdata[int'(LANE_L2_LO)*PIX_W +: PIX_W];
   assign rd_l1_hi = ram_rdata[int'(LANE_L1_HI)*PIX_W +: PIX_W];
   assign rd_l2_hi = ram_rdata[int'(LANE_L2_HI)*PIX_W +: PIX_W];

   assign ram_we   = acc && col[0];
   assign ram_addr = col[CW-1:1];

   // Ageing: previous line moves down to the older slot, new pixels become previous line
   always_comb begin
      ram_wdata = '0;
      ram_wdata[int'(LANE_L1_LO)*PIX_W +: PIX_W] = dpix;
      ram_wdata[int'(LANE_L2_LO)*PIX_W +: PIX_W] = rd_l1_lo;
      ram_wdata[int'(LANE_L1_HI)*PIX_W +: PIX_W] = in_pix;
      ram_wdata[int'(LANE_L2_HI)*PIX_W +: PIX_W] = rd_l1_hi;
   end

   lb3_line_ram #(
      .DEPTH (DEPTH),
      .DW    (DW),
      .AW    (AW)
   ) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (acc),
      .we    (ram_we),
      .addr  (ram_addr),
      .wdata (ram_wdata),
      .rdata (ram_rdata)
   );

   // Column taps for the delayed pixel, chosen by its column parity
   logic [PIX_W-1:0] tap_top, tap_mid;
   logic             shift;

   assign tap_top = dcol[0] ? rd_l2_hi : rd_l2_lo;
   assign tap_mid = dcol[0] ? rd_l1_hi : rd_l1_lo;
   assign shift   = acc && dprimed;

   lb3_window #(
      .PIX_W (PIX_W)
   ) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .shift  (shift),
      .top_px (tap_top),
      .mid_px (tap_mid),
      .bot_px (dpix),
      .win    (win_pix)
   );

   // Valid mask: full neighbourhood inside one frame
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_valid <= 1'b0;
      end else begin
         win_valid <= shift && (drow >= RW'(2)) && (dcol >= CW'(2));
      end
   end

   assign ctr_pix = win_pix[CENTRE_POS*PIX_W +: PIX_W];

   // R3: a window only follows an accepted pixel
   p_valid_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> $past(in_valid));

   // R3: valid is a single-cycle pulse unless pixels keep arriving
   p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && !in_valid) |=> !win_valid);

   // R4: no window for the first two columns of a line
   p_mask_cols_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && col < CW'(3) && col != '0) |=> !win_valid);

   // R8: a write always targets the word read on the previous accepted pixel
   p_write_even_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && ram_we) |-> (dcol[0] == 1'b0 && dcol[CW-1:1] == ram_addr));
endmodule

// File: tb/lb3_window_gen_tb.sv
`timescale 1ns/100ps
module lb3_window_gen_tb;
   localparam int PW = 12;
   localparam int W  = 16;
   localparam int H  = 6;
   localparam int NT = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [PW-1:0] in_pix = '0;
   wire  [NT*PW-1:0] win_pix;
   wire           win_valid;
   wire  [PW-1:0] ctr_pix;

   always #2.5 clk = ~clk;

   lb3_window_gen #(.PIX_W(PW), .IMG_W(W), .IMG_H(H)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_pix    (in_pix),
      .win_pix   (win_pix),
      .win_valid (win_valid),
      .ctr_pix   (ctr_pix)
   );

   int checks = 0;
   int errs   = 0;
   logic [NT*PW-1:0] expq [$];
   int               colq [$];
   int               frmq [$];
   logic [PW-1:0]    img [H][W];
   int  cur_r = 0, cur_c = 0, cur_f = 0;
   int  pr = 0, pc = 0, pf = 0;
   bit  have_prev = 1'b0;
   bit  due_next = 1'b0;
   bit  due_cap = 1'b0;
   bit  idle_cap = 1'b0;
   bit  mon_on = 1'b0;
   int  seen = 0;
   logic [NT*PW-1:0] last_win = '0;
   logic [31:0] seed = 32'h1BADF00D;

   function automatic logic [31:0] nxt();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   function automatic logic [NT*PW-1:0] build(input int r, input int c);
      logic [NT*PW-1:0] v;
      v = '0;
      for (int p = 0; p < NT; p++) begin
         v[p*PW +: PW] = img[r-2+p/3][c-2+p%3];
      end
      return v;
   endfunction

   task automatic send(input logic [PW-1:0] p);
      bit pushed;
      pushed = 1'b0;
      if (have_prev && pr >= 2 && pc >= 2) begin
         expq.push_back(build(pr, pc));
         colq.push_back(pc);
         frmq.push_back(pf);
         pushed = 1'b1;
      end
      img[cur_r][cur_c] = p;
      pr = cur_r; pc = cur_c; pf = cur_f;
      have_prev = 1'b1;
      cur_c++;
      if (cur_c == W) begin
         cur_c = 0; cur_r++;
         if (cur_r == H) begin cur_r = 0; cur_f++; end
      end
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_pix   = p;
      due_next = pushed;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         in_valid = 1'b0;
         due_next = 1'b0;
      end
   endtask

   // Monitor: scoreboard pop, valid timing, stall freeze
   always @(negedge clk) begin
      if (mon_on) begin
         checks++;
         if (win_valid != due_cap) begin
            errs++;
            $display("FAIL R3 valid timing: actual=%0b expected=%0b", win_valid, due_cap);
         end
         if (idle_cap) begin
            checks++;
            if (win_valid || win_pix != last_win) begin
               errs++;
               $display("FAIL R6 stall hold: actual valid=%0b win=%h expected valid=0 win=%h",
                        win_valid, win_pix, last_win);
            end
         end
         if (win_valid) begin
            if (expq.size() == 0) begin
               checks++; errs++;
               $display("FAIL R4 unexpected window: actual=%h expected=none", win_pix);
            end else begin
               logic [NT*PW-1:0] e;
               int ec, ef;
               e  = expq.pop_front();
               ec = colq.pop_front();
               ef = frmq.pop_front();
               seen++;
               checks++;
               if (win_pix != e) begin
                  errs++;
                  $display("FAIL R2 R8 (R7 frame %0d) window col %0d parity %0d: actual=%h expected=%h",
                           ef, ec, ec % 2, win_pix, e);
               end
               checks++;
               if (ctr_pix != e[4*PW +: PW]) begin
                  errs++;
                  $display("FAIL R5 centre: actual=%h expected=%h", ctr_pix, e[4*PW +: PW]);
               end
            end
         end
      end
      due_cap  = due_next && in_valid;
      idle_cap = !in_valid;
      last_win = win_pix;
   end

   // Watchdog
   initial begin
      repeat (50000) @(posedge clk);
      checks++; errs++;
      $display("FAIL R3 watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      checks++;
      if (win_valid !== 1'b0 || win_pix !== '0) begin
         errs++;
         $display("FAIL R1 reset: actual valid=%0b win=%h expected valid=0 win=0", win_valid, win_pix);
      end
      rst_n = 1'b1;
      mon_on = 1'b1;
      idle(4);

      // Frame 0: coordinate ramp, no gaps (R2, R4)
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++)
            send(PW'(r * 64 + c));

      // Frame 1: random data, random gaps (R6, R7)
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++) begin
            if (nxt() % 4 == 0) idle(1 + int'(nxt() % 3));
            send(PW'(nxt()));
         end

      // Frame 2: checkerboard, stall between read and write of each word (R8)
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++) begin
            if (c % 2 == 1) idle(2);
            send(((r + c) % 2 == 1) ? {PW{1'b1}} : '0);
         end

      // Frame 3: falling ramp, stalls at line ends (R4, R6)
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++) begin
            if (c == 0) idle(3);
            send(PW'(4095 - r * 97 - c * 5));
         end

      // Flush last window with the first pixel of a fresh frame
      send(PW'(7));
      idle(6);

      // R4: exact window count per frame
      checks++;
      if (seen != 4 * (H - 2) * (W - 2) || expq.size() != 0) begin
         errs++;
         $display("FAIL R4 window count: actual=%0d pending=%0d expected=%0d",
                  seen, expq.size(), 4 * (H - 2) * (W - 2));
      end
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end
endmodule